// File: doc/BRIEF.md
# Oscillation Stabilization Wait Controller

This block decides when the clock tree may be used after a reset or a wake-up. A free-running timebase counter is cleared at the start of each wait. The wait ends when one selected counter bit first rises. A 2-bit select register, written by software, chooses which bit is used. The block drives a clock-ready flag and a wait-active flag. The oscillator, the PLL and the clock multiplexers that act on these flags are outside this block.

The select register reacts differently to each class of reset. The following events set it back to the shortest code:
- the external initialization pin;
- the RC-oscillator watchdog strobe;
- the clock-supervisor strobe.

A timebase-watchdog reset and an operation reset keep the value that was programmed before them, and the wait that follows uses that value. A wait is always inserted after a timebase-watchdog reset and after an interrupt wake-up from stop mode, even if the clock never stopped. Software may set the short code before it enters stop mode so that the wake-up wait costs little.

Top module: `osc_wait_ctrl`

## Requirements
- R1: While `pinInitN` is low, `waitActive` is 1, `clkReady` is 0, the select field is forced to code 00 and the counter is held at zero. After release, `clkReady` rises on the (2^TAP_C0+1)th rising clock edge.
- R2: After the edge that accepts a trigger, `clkReady` rises on the (2^N+1)th rising edge. N is TAP_C0, TAP_C1, TAP_C2 or TAP_C3 for latched code 00, 01, 10 or 11. The defaults are 9, 13, 15 and 17.
- R3: Once `clkReady` is high, it stays high until the next trigger.
- R4: A pulse on `rcWdogRst` or `clkSupRst` sets the select field to 00 and starts a wait of the code-00 length. This clear wins over a write in the same cycle.
- R5: A pulse on `tbWdogRst` starts a wait and leaves the select field unchanged. The wait uses the field's current value.
- R6: A pulse on `opRst` starts a wait and leaves the select field unchanged. The wait uses the field's current value.
- R7: `stopMode` alone does not lower `clkReady`. A `wakeIrq` pulse while `stopMode` is 1 starts a wait with the current field value.
- R8: A `wakeIrq` pulse while `stopMode` is 0 has no effect.
- R9: A write to the select field during a wait does not change that wait's length. The new code is used from the next trigger.
- R10: From the edge that accepts any trigger, `clkReady` is 0 and `waitActive` is 1. `waitActive` is always the inverse of `clkReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| pinInitN | input | 1 | External initialization pin, active low, asynchronous |
| rcWdogRst | input | 1 | RC-oscillator watchdog reset strobe (power class) |
| clkSupRst | input | 1 | Clock-supervisor reset strobe (power class) |
| tbWdogRst | input | 1 | Timebase-watchdog reset strobe (keeps field) |
| opRst | input | 1 | Operation reset strobe (keeps field) |
| stopMode | input | 1 | Device is in main-stop or sub-stop mode |
| wakeIrq | input | 1 | Wake-up interrupt strobe |
| selWrEn | input | 1 | Write enable for the select field |
| selWrData | input | 2 | Select code to write |
| clkReady | output | 1 | Clock may be used |
| waitActive | output | 1 | A stabilization wait is in progress |

## Verification
The select field can only be observed through the length of the next wait. A wrong value, whether it was wrongly retained or wrongly cleared, shows up as `clkReady` rising several edges early or late on the first trigger after the fault. Each scenario therefore measures the exact edge count, with taps chosen so that every code gives a distinct count. A stuck FSM or a missed trigger appears at once: either `clkReady` is still high on the edge after the trigger, or it never rises within the bounded count.

// File: rtl/owc_pkg.sv
package owc_pkg;

  typedef enum logic {
    ST_WAIT  = 1'b0,
    ST_READY = 1'b1
  } owc_state_t;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic cntClear;   // restart the timebase at a wait start
    logic latchSel;   // copy the programmed code into the active code
    logic selClear;   // power-class reset: force the code to 00
  } owc_strobe_t;

  function automatic int maxOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic int minOf4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b < m) m = b;
    if (c < m) m = c;
    if (d < m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/owc_datapath.sv
module owc_datapath
  import owc_pkg::*;
#(
  parameter int TAP_C0 = 9,
  parameter int TAP_C1 = 13,
  parameter int TAP_C2 = 15,
  parameter int TAP_C3 = 17,
  parameter int CNT_W  = 18,
  parameter int SEL_W  = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  owc_strobe_t      strb,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  output logic             tapHit
);

  localparam int NUM_CODES = 1 << SEL_W;
  localparam int TAPS [4] = '{TAP_C0, TAP_C1, TAP_C2, TAP_C3};

  logic [CNT_W-1:0]     count;
  logic [SEL_W-1:0]     selReg;
  logic [SEL_W-1:0]     activeSel;
  logic [NUM_CODES-1:0] tapVec;

  // free-running timebase, cleared when a wait starts
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              count <= '0;
    else if (strb.cntClear) count <= '0;
    else                    count <= count + 1'b1;
  end

  // programmed select field: only power-class events clear it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              selReg <= '0;
    else if (strb.selClear) selReg <= '0;
    else if (selWrEn)       selReg <= selWrData;
  end

  // code in force for the current wait
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              activeSel <= '0;
    else if (strb.selClear) activeSel <= '0;
    else if (strb.latchSel) activeSel <= selReg;
  end

  for (genvar i = 0; i < NUM_CODES; i++) begin : g_tap
    assign tapVec[i] = count[TAPS[i]];
  end

  assign tapHit = tapVec[activeSel];

endmodule

// File: rtl/owc_ctrl.sv
module owc_ctrl
  import owc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rcWdogRst,
  input  logic        clkSupRst,
  input  logic        tbWdogRst,
  input  logic        opRst,
  input  logic        stopMode,
  input  logic        wakeIrq,
  input  logic        tapHit,
  output owc_strobe_t strb,
  output logic        clkReady,
  output logic        waitActive
);

  owc_state_t state, stateNext;
  logic pwrClass, keepClass, wakeTrig, trigger;

  assign pwrClass  = rcWdogRst | clkSupRst;
  assign keepClass = tbWdogRst | opRst;
  assign wakeTrig  = stopMode & wakeIrq;
  assign trigger   = pwrClass | keepClass | wakeTrig;

  always_comb begin
    strb          = '0;
    strb.cntClear = trigger;
    strb.selClear = pwrClass;
    strb.latchSel = trigger & ~pwrClass;
  end

  always_comb begin
    stateNext = state;
    if (trigger)                       stateNext = ST_WAIT;
    else if (state == ST_WAIT && tapHit) stateNext = ST_READY;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WAIT;
    else       state <= stateNext;
  end

  assign clkReady   = (state == ST_READY);
  assign waitActive = (state == ST_WAIT);

endmodule

// File: rtl/osc_wait_ctrl.sv
module osc_wait_ctrl
  import owc_pkg::*;
#(
  parameter int TAP_C0 = 9,
  parameter int TAP_C1 = 13,
  parameter int TAP_C2 = 15,
  parameter int TAP_C3 = 17
) (
  input  logic       clk,
  input  logic       pinInitN,
  input  logic       rcWdogRst,
  input  logic       clkSupRst,
  input  logic       tbWdogRst,
  input  logic       opRst,
  input  logic       stopMode,
  input  logic       wakeIrq,
  input  logic       selWrEn,
  input  logic [1:0] selWrData,
  output logic       clkReady,
  output logic       waitActive
);

  localparam int CNT_W = maxOf4(TAP_C0, TAP_C1, TAP_C2, TAP_C3) + 1;

  owc_strobe_t strb;
  logic        tapHit;

  owc_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (pinInitN),
    .rcWdogRst  (rcWdogRst),
    .clkSupRst  (clkSupRst),
    .tbWdogRst  (tbWdogRst),
    .opRst      (opRst),
    .stopMode   (stopMode),
    .wakeIrq    (wakeIrq),
    .tapHit     (tapHit),
    .strb       (strb),
    .clkReady   (clkReady),
    .waitActive (waitActive)
  );

  owc_datapath #(
    .TAP_C0 (TAP_C0),
    .TAP_C1 (TAP_C1),
    .TAP_C2 (TAP_C2),
    .TAP_C3 (TAP_C3),
    .CNT_W  (CNT_W),
    .SEL_W  (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (pinInitN),
    .strb      (strb),
    .selWrEn   (selWrEn),
    .selWrData (selWrData),
    .tapHit    (tapHit)
  );

endmodule

// File: rtl/owc_checker.sv
module owc_checker
  import owc_pkg::*;
#(
  parameter int TAP_C0 = 9,
  parameter int TAP_C1 = 13,
  parameter int TAP_C2 = 15,
  parameter int TAP_C3 = 17
) (
  input logic clk,
  input logic pinInitN,
  input logic rcWdogRst,
  input logic clkSupRst,
  input logic tbWdogRst,
  input logic opRst,
  input logic stopMode,
  input logic wakeIrq,
  input logic clkReady,
  input logic waitActive
);

  localparam int MIN_WAIT = (1 << minOf4(TAP_C0, TAP_C1, TAP_C2, TAP_C3)) + 1;

  logic trig;
  logic [31:0] waitCnt;

  assign trig = rcWdogRst | clkSupRst | tbWdogRst | opRst | (stopMode & wakeIrq);

  // edges since the last wait start, saturating
  always_ff @(posedge clk or negedge pinInitN) begin
    if (!pinInitN)              waitCnt <= '0;
    else if (trig)              waitCnt <= '0;
    else if (waitCnt != '1)     waitCnt <= waitCnt + 1;
  end

  assert_trigger_drops_ready_R10: assert property (@(posedge clk) disable iff (!pinInitN)
    trig |=> (!clkReady && waitActive));

  assert_ready_sticky_R3: assert property (@(posedge clk) disable iff (!pinInitN)
    (clkReady && !trig) |=> clkReady);

  assert_wake_outside_stop_ignored_R8: assert property (@(posedge clk) disable iff (!pinInitN)
    (clkReady && wakeIrq && !stopMode && !rcWdogRst && !clkSupRst && !tbWdogRst && !opRst)
      |=> clkReady);

  assert_no_early_ready_R2: assert property (@(posedge clk) disable iff (!pinInitN)
    $rose(clkReady) |-> (waitCnt >= MIN_WAIT));

  assert_power_reset_waits_R4: assert property (@(posedge clk) disable iff (!pinInitN)
    (rcWdogRst || clkSupRst) |=> waitActive);

endmodule

bind osc_wait_ctrl owc_checker #(
  .TAP_C0 (TAP_C0),
  .TAP_C1 (TAP_C1),
  .TAP_C2 (TAP_C2),
  .TAP_C3 (TAP_C3)
) u_chk (
  .clk        (clk),
  .pinInitN   (pinInitN),
  .rcWdogRst  (rcWdogRst),
  .clkSupRst  (clkSupRst),
  .tbWdogRst  (tbWdogRst),
  .opRst      (opRst),
  .stopMode   (stopMode),
  .wakeIrq    (wakeIrq),
  .clkReady   (clkReady),
  .waitActive (waitActive)
);

// File: tb/osc_wait_ctrl_test.sv
`timescale 1ns/1ps
module osc_wait_ctrl_test;

  localparam int T0 = 2, T1 = 3, T2 = 4, T3 = 5;
  localparam int W0 = (1 << T0) + 1;
  localparam int W1 = (1 << T1) + 1;
  localparam int W2 = (1 << T2) + 1;
  localparam int W3 = (1 << T3) + 1;

  logic clk = 1'b0;
  logic pinInitN = 1'b0;
  logic rcWdogRst = 0, clkSupRst = 0, tbWdogRst = 0, opRst = 0;
  logic stopMode = 0, wakeIrq = 0, selWrEn = 0;
  logic [1:0] selWrData = 2'b00;
  logic clkReady, waitActive;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;   // 125 MHz

  osc_wait_ctrl #(.TAP_C0(T0), .TAP_C1(T1), .TAP_C2(T2), .TAP_C3(T3)) uut (
    .clk(clk), .pinInitN(pinInitN), .rcWdogRst(rcWdogRst), .clkSupRst(clkSupRst),
    .tbWdogRst(tbWdogRst), .opRst(opRst), .stopMode(stopMode), .wakeIrq(wakeIrq),
    .selWrEn(selWrEn), .selWrData(selWrData), .clkReady(clkReady), .waitActive(waitActive)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writeSel(input logic [1:0] code);
    @(negedge clk); selWrEn = 1'b1; selWrData = code;
    @(negedge clk); selWrEn = 1'b0;
  endtask

  // kind: 0 rcWdog, 1 clkSup, 2 tbWdog, 3 opRst, 4 wake
  task automatic fire(input int kind);
    @(negedge clk);
    case (kind)
      0: rcWdogRst = 1'b1;
      1: clkSupRst = 1'b1;
      2: tbWdogRst = 1'b1;
      3: opRst     = 1'b1;
      default: wakeIrq = 1'b1;
    endcase
    @(negedge clk);
    rcWdogRst = 0; clkSupRst = 0; tbWdogRst = 0; opRst = 0; wakeIrq = 0;
    check(!clkReady && waitActive, "R10 trigger drops ready", clkReady, 0);
  endtask

  // counts edges after the accepting edge until clkReady is seen high
  task automatic measure(output int n, input bit midWrite, input logic [1:0] code);
    n = 1;
    forever begin
      if (clkReady || n > 200) break;
      if (midWrite && n == 2) begin selWrEn = 1'b1; selWrData = code; end
      else selWrEn = 1'b0;
      @(posedge clk); n++;
      @(negedge clk);
    end
    selWrEn = 1'b0;
    n = n - 1;
  endtask

  task automatic measureRelease(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (!clkReady && n <= 200);
  endtask

  task automatic testResetPin();
    int n;
    repeat (5) @(negedge clk);
    check(waitActive && !clkReady, "R1 held in wait during pin reset", clkReady, 0);
    pinInitN = 1'b1;
    measureRelease(n);
    check(n == W0, "R1 wait length after pin release", n, W0);
  endtask

  task automatic testCodesKept();
    int n;
    writeSel(2'b11);
    fire(2); measure(n, 0, 2'b00);
    check(n == W3, "R5 R2 code 11 kept over timebase watchdog", n, W3);
    writeSel(2'b01);
    fire(3); measure(n, 0, 2'b00);
    check(n == W1, "R6 R2 code 01 kept over operation reset", n, W1);
    writeSel(2'b10);
    fire(2); measure(n, 0, 2'b00);
    check(n == W2, "R2 code 10 length", n, W2);
  endtask

  task automatic testSticky();
    int bad = 0;
    repeat (20) begin
      @(negedge clk);
      if (!clkReady || waitActive) bad++;
    end
    check(bad == 0, "R3 ready stays high", bad, 0);
  endtask

  task automatic testStopWake();
    int n;
    int bad = 0;
    @(negedge clk); stopMode = 1'b1;
    repeat (10) begin @(negedge clk); if (!clkReady) bad++; end
    check(bad == 0, "R7 stop mode alone keeps ready", bad, 0);
    fire(4); measure(n, 0, 2'b00);
    check(n == W2, "R7 wake from stop uses field 10", n, W2);
    @(negedge clk); stopMode = 1'b0;
    @(negedge clk); wakeIrq = 1'b1;
    @(negedge clk); wakeIrq = 1'b0;
    bad = 0;
    repeat (5) begin @(negedge clk); if (!clkReady) bad++; end
    check(bad == 0, "R8 wake outside stop ignored", bad, 0);
  endtask

  task automatic testMidWrite();
    int n;
    writeSel(2'b11);
    fire(2); measure(n, 1, 2'b00);
    check(n == W3, "R9 write during wait leaves length", n, W3);
    fire(2); measure(n, 0, 2'b00);
    check(n == W0, "R9 written code used on next wait", n, W0);
  endtask

  task automatic testPowerClass();
    int n;
    writeSel(2'b11);
    fire(0); measure(n, 0, 2'b00);
    check(n == W0, "R4 rc watchdog wait uses code 00", n, W0);
    fire(2); measure(n, 0, 2'b00);
    check(n == W0, "R4 rc watchdog cleared field", n, W0);
    writeSel(2'b10);
    @(negedge clk); clkSupRst = 1'b1; selWrEn = 1'b1; selWrData = 2'b11;
    @(negedge clk); clkSupRst = 1'b0; selWrEn = 1'b0;
    check(!clkReady && waitActive, "R10 clock supervisor drops ready", clkReady, 0);
    measure(n, 0, 2'b00);
    check(n == W0, "R4 clock supervisor wait uses code 00", n, W0);
    fire(3); measure(n, 0, 2'b00);
    check(n == W0, "R4 clear wins over same-cycle write", n, W0);
  endtask

  task automatic testPinMidWait();
    int n;
    int bad = 0;
    writeSel(2'b11);
    fire(2);
    repeat (3) @(negedge clk);
    pinInitN = 1'b0;
    repeat (40) begin @(negedge clk); if (clkReady || !waitActive) bad++; end
    check(bad == 0, "R1 pin held low keeps wait", bad, 0);
    pinInitN = 1'b1;
    measureRelease(n);
    check(n == W0, "R1 pin reset forces code 00", n, W0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    testResetPin();
    testCodesKept();
    testSticky();
    testStopWake();
    testMidWrite();
    testPowerClass();
    testPinMidWait();
    finishRun();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

endmodule